// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel NOR flash. It waits for an embedded program or erase to finish and then says how it ended. A completion flag alone cannot be trusted, so the controller reads the device's status word over and over through a small request/response port. It judges completion by comparing two reads in a row. For a program it also compares the final word with the data that was written. It checks the error flag and the supply-voltage flag, and it gives up after a programmable number of cycles.

The host pulses `start` with the operation kind and the expected word, then waits for a one-cycle `done` with a 2-bit result. Issuing command sequences, addressing and bus timing belong to the surrounding logic.

The read port is valid/ready:
- `rd_valid` stays high until `rd_ready` is sampled high. That is the only back-pressure.
- Only one read is ever outstanding. Its data returns later on `rsp_valid`/`rsp_data`, which the controller always accepts.
- A response that arrives while no read is outstanding is dropped.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset `done` and `rd_valid` are low and `status` is 0.
- R2: `start` is taken only when no poll is running. `op_erase` and `exp_data` are captured at that moment. A `start` pulse or a change of those inputs during a poll has no effect on its result or on its number of reads.
- R3: Reads are issued in pairs, with one read outstanding at a time. `rd_valid` stays high until `rd_ready` is seen, and it drops only on a handshake or on a timeout result.
- R4: A pair is "settled" when bit 6 is equal in both words. For an erase, a settled pair gives status 0 (ok).
- R5: For a program, a settled pair gives status 0 when the second word equals the captured expected word in all bits, and status 1 (fail) otherwise.
- R6: In a toggling pair (bit 6 differs), when bit 3 is set in both words, the result is status 2 (low supply). This takes priority over bit 5.
- R7: In a toggling pair with bit 5 set in both words and bit 3 not set in both, exactly one more pair is read. If that pair toggles, the result is status 1. If it settles, R4/R5 decide.
- R8: A toggling pair without a joint flag starts another pair.
- R9: If no result is reached, `done` comes with status 3 (timeout) on the (WD_CYCLES+1)-th clock edge after the edge that took `start`.
- R10: `done` is a one-cycle pulse, and `status` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (ignored while busy) |
| op_erase | input | 1 | 1 = erase in progress, 0 = program |
| exp_data | input | DW | Word being programmed |
| rd_valid | output | 1 | Status read request |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | DW | Status/data word |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 ok, 1 fail, 2 low supply, 3 timeout |

## Verification
The hardest path to reach is the error re-check. The error flag must be present in both reads of a toggling pair, and the toggle must then stop exactly inside the single extra pair. Reaching this depends on where the busy-to-idle boundary falls relative to pair alignment.

The bench's flash model returns busy words for a chosen number of reads, with bit 6 equal to the read index parity. The error flag can be raised on the last two busy reads or on all of them. Sweeping the busy length from 0 to 5 therefore moves the boundary across both positions of a pair, with and without a preceding flagged pair, and request stalls and response latency are varied on top of this.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_ERR  = 5;
  localparam int BIT_VPP  = 3;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_FAIL    = 2'd1,
    RES_LOWV    = 2'd2,
    RES_TIMEOUT = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    V_AGAIN, V_RECHECK, V_OK, V_FAIL, V_LOWV
  } verdict_e;

  typedef struct packed {
    logic tog;
    logic err;
    logic vpp;
  } flags_t;
endpackage

// File: rtl/fpc_watchdog.sv
module fpc_watchdog #(
  parameter int WD_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WD_CYCLES);

  logic [CW-1:0] cnt;

  assign expired = (cnt >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fpc_pair_reader.sv
module fpc_pair_reader
  import fpc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          pair_valid,
  output flags_t        first_flags,
  output logic [DW-1:0] second_word
);
  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT} rd_st_e;

  rd_st_e st;
  logic   on_second;

  assign rd_valid = (st == RD_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= RD_IDLE;
      on_second   <= 1'b0;
      pair_valid  <= 1'b0;
      first_flags <= '0;
      second_word <= '0;
    end else begin
      pair_valid <= 1'b0;
      if (abort) begin
        st        <= RD_IDLE;
        on_second <= 1'b0;
      end else begin
        unique case (st)
          RD_IDLE: if (go) begin
            st        <= RD_REQ;
            on_second <= 1'b0;
          end
          RD_REQ: if (rd_ready) st <= RD_WAIT;
          RD_WAIT: if (rsp_valid) begin
            if (!on_second) begin
              first_flags <= '{tog: rsp_data[BIT_TOG], err: rsp_data[BIT_ERR],
                               vpp: rsp_data[BIT_VPP]};
              on_second   <= 1'b1;
              st          <= RD_REQ;
            end else begin
              second_word <= rsp_data;
              pair_valid  <= 1'b1;
              st          <= RD_IDLE;
            end
          end
          default: st <= RD_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpc_judge.sv
module fpc_judge
  import fpc_pkg::*;
#(
  parameter int DW = 16
) (
  input  flags_t        f0,
  input  logic [DW-1:0] w1,
  input  logic [DW-1:0] expect_word,
  input  logic          is_erase,
  input  logic          rechecking,
  output verdict_e      verdict
);
  logic toggling, both_err, both_vpp, data_match;

  always_comb begin
    toggling   = f0.tog ^ w1[BIT_TOG];
    both_err   = f0.err & w1[BIT_ERR];
    both_vpp   = f0.vpp & w1[BIT_VPP];
    data_match = (w1 == expect_word);
    if (!toggling)
      verdict = (is_erase || data_match) ? V_OK : V_FAIL;
    else if (rechecking)
      verdict = V_FAIL;
    else if (both_vpp)
      verdict = V_LOWV;
    else if (both_err)
      verdict = V_RECHECK;
    else
      verdict = V_AGAIN;
  end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import fpc_pkg::*;
#(
  parameter int DW        = 16,
  parameter int WD_CYCLES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [DW-1:0] exp_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic [1:0]    status
);
  typedef enum logic {S_IDLE, S_POLL} st_e;

  st_e           st;
  logic          busy;
  logic          go, rechk, op_q;
  logic [DW-1:0] exp_q;
  logic          wd_clr, wd_exp, abort;
  logic          pair_valid;
  flags_t        f0;
  logic [DW-1:0] w1;
  verdict_e      verdict;

  assign busy   = (st == S_POLL);
  assign wd_clr = (st == S_IDLE) && start;
  assign abort  = busy && wd_exp;

  fpc_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .run(busy), .expired(wd_exp)
  );

  fpc_pair_reader #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pair_valid(pair_valid), .first_flags(f0), .second_word(w1)
  );

  fpc_judge #(.DW(DW)) u_judge (
    .f0(f0), .w1(w1), .expect_word(exp_q), .is_erase(op_q),
    .rechecking(rechk), .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      go     <= 1'b0;
      done   <= 1'b0;
      status <= RES_OK;
      rechk  <= 1'b0;
      op_q   <= 1'b0;
      exp_q  <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          op_q  <= op_erase;
          exp_q <= exp_data;
          rechk <= 1'b0;
          go    <= 1'b1;
          st    <= S_POLL;
        end
        S_POLL: begin
          if (wd_exp) begin
            done   <= 1'b1;
            status <= RES_TIMEOUT;
            st     <= S_IDLE;
          end else if (pair_valid) begin
            unique case (verdict)
              V_AGAIN:   go <= 1'b1;
              V_RECHECK: begin go <= 1'b1; rechk <= 1'b1; end
              V_OK:      begin done <= 1'b1; status <= RES_OK;   st <= S_IDLE; end
              V_FAIL:    begin done <= 1'b1; status <= RES_FAIL; st <= S_IDLE; end
              V_LOWV:    begin done <= 1'b1; status <= RES_LOWV; st <= S_IDLE; end
              default:   go <= 1'b1;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int WD_CYCLES = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       done,
  input logic [1:0] status
);
  logic [31:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) win <= '0;
    else                 win <= win + 1;
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_status_only_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done);

  assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid || done));

  assert_quiet_after_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_valid && !busy));

  assert_watchdog_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (win <= 32'(WD_CYCLES)));
endmodule

bind flash_poll_ctrl fpc_checker #(.WD_CYCLES(WD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .done(done), .status(status)
);

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WD = 300;

  logic clk = 0, rst_n = 0;
  logic start = 0, op_erase = 0;
  logic [DW-1:0] exp_data = '0;
  logic rd_valid, rd_ready = 1, rsp_valid = 0;
  logic [DW-1:0] rsp_data = '0;
  logic done;
  logic [1:0] status;

  int total = 0, bad = 0;

  // flash model scenario
  bit s_erase, s_forever, s_stall;
  int s_n, s_err, s_vpp, s_bad, s_lat;
  logic [DW-1:0] s_exp;
  int rcnt = 0, pend_cnt = 0;
  logic [DW-1:0] pend_word;

  flash_poll_ctrl #(.DW(DW), .WD_CYCLES(WD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .exp_data(exp_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] word_at(int n);
    logic [DW-1:0] w;
    if (s_forever || n < s_n) begin
      w = '0;
      w[7] = s_erase ? 1'b0 : ~s_exp[7];
      w[6] = n[0];
      w[5] = (s_err == 2) || (s_err == 1 && n >= s_n - 2);
      w[3] = (s_vpp != 0);
    end else if (s_erase) w = '1;
    else w = s_exp ^ ((s_bad == 1) ? 16'h0080 : (s_bad == 2) ? 16'h0001 : 16'h0000);
    return w;
  endfunction

  task automatic predict(output int code, output int reads);
    bit rk = 0;
    code = 3; reads = 0;
    for (int p = 0; p < 100; p++) begin
      logic [DW-1:0] a, b;
      a = word_at(2*p); b = word_at(2*p+1); reads = 2*p + 2;
      if (a[6] == b[6]) begin
        code = (!s_erase && b != s_exp) ? 1 : 0; return;
      end else if (rk) begin code = 1; return; end
      else if (a[3] && b[3]) begin code = 2; return; end
      else if (a[5] && b[5]) rk = 1;
    end
  endtask

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (erase=%0d n=%0d err=%0d vpp=%0d bad=%0d)",
               tag, act, expv, s_erase, s_n, s_err, s_vpp, s_bad);
    end
  endtask

  // flash read responder
  initial forever begin
    @(posedge clk);
    rsp_valid <= 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin rsp_valid <= 1'b1; rsp_data <= pend_word; end
    end
    if (rd_valid && rd_ready) begin
      pend_word = word_at(rcnt); rcnt++; pend_cnt = s_lat;
    end
    rd_ready <= s_stall ? ~rd_ready : 1'b1;
  end

  task automatic run(input bit ign, output int code, output int reads, output int cyc);
    int extra = 0;
    rcnt = 0; pend_cnt = 0;
    @(negedge clk);
    start = 1; op_erase = s_erase; exp_data = s_exp;
    @(negedge clk);
    start = 0; exp_data = ~s_exp;          // latched value must be used (R2)
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
      start = ign && (cyc == 2);
      op_erase = ign ? !s_erase : s_erase;
    end
    start = 0;
    code = status; reads = rcnt;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) extra++; end
    if (ign) chk("R2 single result", extra, 0);
  endtask

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, r, cy, pc, pr;
    s_lat = 1; s_stall = 0; s_forever = 0;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 status", status, 0);
    rst_n = 1;

    for (int er = 0; er < 2; er++)
      for (int n = 0; n < 6; n++)
        for (int e = 0; e < 3; e++)
          for (int v = 0; v < 2; v++)
            for (int b = 0; b < (er ? 1 : 3); b++)
              for (int l = 1; l < 3; l++) begin
                s_erase = er[0]; s_n = n; s_err = e; s_vpp = v; s_bad = b;
                s_lat = l; s_stall = n[0] ^ l[0];
                s_exp = 16'hA500 | 16'((n*37 + e*11 + v*69 + b*130) & 8'hFF);
                predict(pc, pr);
                run(1'b0, c, r, cy);
                if (pc == 2)      chk("R6 low supply", c, pc);
                else if (e != 0 && pc == 1) chk("R7 recheck fail", c, pc);
                else if (er)      chk("R4 erase result", c, pc);
                else              chk("R5 program result", c, pc);
                chk((e != 0) ? "R7 read count" : "R8 read count", r, pr);
                chk("R3 pairs", r % 2, 0);
              end

    // start while busy ignored, inputs changed mid-poll
    s_erase = 0; s_n = 4; s_err = 0; s_vpp = 0; s_bad = 0; s_lat = 2; s_stall = 1;
    s_exp = 16'h3C81;
    predict(pc, pr);
    run(1'b1, c, r, cy);
    chk("R2 status with ignored start", c, pc);
    chk("R2 reads with ignored start", r, pr);

    // watchdog
    for (int er = 0; er < 2; er++) begin
      s_erase = er[0]; s_forever = 1; s_err = 0; s_vpp = 0; s_lat = 2; s_stall = 1;
      run(1'b0, c, r, cy);
      chk("R9 timeout code", c, 3);
      chk("R9 timeout edge", cy, WD + 1);
      s_forever = 0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule